// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers up to 64 device interrupt request lines into one shared pending vector and hands each of up to four processors its own filtered view of that vector. Every processor has a 64-bit enable mask. Its view is the bitwise AND of the mask with the shared pending vector, and its interrupt output is high while any bit of that view is set. A pending bit is set when its device line rises and cleared when the line falls. A fall on a bit that is not pending counts as a spurious clear and changes nothing. The device lines are assumed to be synchronous to `clk`, and `rst_n` is assumed to be released synchronously to it.

Software programs the masks and reads the views and the pending vector through a single-beat 64-bit register port. A request is accepted in the cycle `req_valid` is high. The answer (`rsp_valid`, `rsp_err`, `rsp_rdata`) appears one clock later. The register is chosen from the byte offset in one of two ways. In flat mode the register number is the offset shifted right by 6. In banked mode the processor index is taken directly from offset bits [9:4].

Top module: `dev_irq_router`

## Requirements
- R1: For every processor c, the view read back for c equals that processor's mask ANDed with the pending vector, both taken in the same cycle.
- R2: A mask write that enables a bit that is already pending raises that processor's `irq_out` bit one clock after the write is accepted.
- R3: A mask write that clears every enabled pending bit drops that processor's `irq_out` bit one clock after the write is accepted.
- R4: A rising device line sets its pending bit at the next clock edge. One clock after that, `irq_out` is high for exactly those processors whose mask has that bit set.
- R5: A falling device line whose pending bit is set clears the bit. One clock later, every processor that was receiving only that bit has its `irq_out` bit dropped.
- R6: A falling device line whose pending bit is clear changes nothing. A line already high when reset is released is not pending until it rises again.
- R7: Flat mode applies when offset bit 11 is 0, and the register number is offset[10:6]. Register number n<4 is the mask of processor n, 4..7 is the view of processor n-4, and 8 is the pending vector. Banked mode applies when offset bit 11 is 1: offset bit 10 selects the mask (0) or the view (1), and offset[9:4] is the processor index. Offset bits [3:0] are ignored.
- R8: Only `req_size` = 2'b11 (64-bit) is legal. Any other size returns `rsp_err`=1 and read data 0, and leaves every mask unchanged.
- R9: A write to a view or to the pending vector, an unmapped flat register number (9 or above), or a banked index of 4 or above returns `rsp_err`=1 and read data 0, and changes no state.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high, and low otherwise.
- R11: Reset clears every mask, the pending vector, `irq_out` and `rsp_valid`.
- R12: A mask write and a device line edge accepted at the same clock edge both take effect, and `irq_out` reflects the combined state one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 64 | Device interrupt request lines |
| req_valid | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_size | input | 2 | Access size code, 2'b11 = 64-bit |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data (0 on writes and errors) |
| irq_out | output | 4 | Level interrupt to each processor |

## Verification
A mask write and a device line edge can land on the same clock edge. When they do, the new mask must be combined with the updated pending vector, and neither update may mask the other. The bench provokes this directly: in one cycle it presents a mask write for processor 3 that enables bit 40 and also raises device line 40. The behavioural reference model, updated on every clock, predicts that processors 2 and 3 fire together. The checks then compare `irq_out` and the read-back view of processor 3 against that prediction.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_MASK = 2'd1,
    RK_VIEW = 2'd2,
    RK_RAW  = 2'd3
  } reg_kind_e;

  localparam int BANK_BIT = 11;
  localparam int VIEW_BIT = 10;
  localparam int IDX_HI   = 9;
  localparam int IDX_LO   = 4;
  localparam int FLAT_HI  = 10;
  localparam int FLAT_LO  = 6;
  localparam logic [1:0] SIZE_DWORD = 2'b11;

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] dev_req,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] prev_q
);

  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] fall_w;
  logic [NUM_SRC-1:0] raw_nx;

  // A fall only counts when the pending bit is set; others are spurious.
  always_comb begin
    rise_w = dev_req & ~prev_q;
    fall_w = ~dev_req & prev_q & raw_q;
    raw_nx = (raw_q | rise_w) & ~fall_w;
  end

  // prev resets high so a line held high through reset is not a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      prev_q <= '1;
    end else begin
      raw_q  <= raw_nx;
      prev_q <= dev_req;
    end
  end

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_kind_e         dec_kind,
  output logic [CPU_W-1:0]  dec_idx,
  output logic              dec_err,
  output logic [NUM_CPU-1:0] mask_we
);

  localparam logic [5:0] N6      = 6'(NUM_CPU);
  localparam logic [5:0] N6X2    = 6'(2 * NUM_CPU);

  logic [5:0] sel;
  logic [5:0] flat_num;
  logic       size_ok;
  logic       unused_addr_lo;

  assign unused_addr_lo = ^req_addr[IDX_LO-1:0];
  assign flat_num       = {1'b0, req_addr[FLAT_HI:FLAT_LO]};
  assign size_ok        = (req_size == SIZE_DWORD);

  always_comb begin
    dec_kind = RK_NONE;
    sel      = '0;
    if (req_addr[BANK_BIT]) begin
      sel      = req_addr[IDX_HI:IDX_LO];
      dec_kind = req_addr[VIEW_BIT] ? RK_VIEW : RK_MASK;
      if (sel >= N6) dec_kind = RK_NONE;
    end else if (flat_num < N6) begin
      sel      = flat_num;
      dec_kind = RK_MASK;
    end else if (flat_num < N6X2) begin
      sel      = flat_num - N6;
      dec_kind = RK_VIEW;
    end else if (flat_num == N6X2) begin
      dec_kind = RK_RAW;
    end
  end

  assign dec_idx = sel[CPU_W-1:0];
  assign dec_err = !size_ok || (dec_kind == RK_NONE) ||
                   (req_we && (dec_kind != RK_MASK));

  always_comb begin
    mask_we = '0;
    if (req_valid && req_we && !dec_err)
      mask_we[dec_idx] = 1'b1;
  end

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] view,
  output logic               irq_q
);

  logic [NUM_SRC-1:0] mask_nx;
  logic               irq_nx;

  always_comb begin
    mask_nx = mask_we ? mask_wdata : mask_q;
    view    = mask_q & raw_q;
    irq_nx  = |view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nx;
      irq_q  <= irq_nx;
    end
  end

endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] dev_req,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_CPU-1:0] irq_out
);

  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [NUM_SRC-1:0]              src_raw;
  logic [NUM_SRC-1:0]              src_prev;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] view_all;
  logic [NUM_CPU-1:0]              mask_we;
  reg_kind_e                       dec_kind;
  logic [CPU_W-1:0]                dec_idx;
  logic                            dec_err;

  logic                            rsp_valid_nx;
  logic                            rsp_err_nx;
  logic [DATA_W-1:0]               rsp_rdata_nx;
  logic [DATA_W-1:0]               rd_mux;

  irq_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_req (dev_req),
    .raw_q   (src_raw),
    .prev_q  (src_prev)
  );

  irq_csr_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_dec (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .dec_kind  (dec_kind),
    .dec_idx   (dec_idx),
    .dec_err   (dec_err),
    .mask_we   (mask_we)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
    irq_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (mask_we[c]),
      .mask_wdata (req_wdata[NUM_SRC-1:0]),
      .raw_q      (src_raw),
      .mask_q     (mask_all[c]),
      .view       (view_all[c]),
      .irq_q      (irq_out[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (dec_kind)
      RK_MASK: rd_mux[NUM_SRC-1:0] = mask_all[dec_idx];
      RK_VIEW: rd_mux[NUM_SRC-1:0] = view_all[dec_idx];
      RK_RAW:  rd_mux[NUM_SRC-1:0] = src_raw;
      default: rd_mux = '0;
    endcase
  end

  always_comb begin
    rsp_valid_nx = req_valid;
    rsp_err_nx   = req_valid && dec_err;
    rsp_rdata_nx = (req_valid && !req_we && !dec_err) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_nx;
      rsp_err   <= rsp_err_nx;
      rsp_rdata <= rsp_rdata_nx;
    end
  end

endmodule

// File: rtl/dev_irq_router_chk.sv
module dev_irq_router_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_SRC-1:0]                dev_req,
  input logic [NUM_SRC-1:0]                prev_q,
  input logic [NUM_SRC-1:0]                raw_q,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_all,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0]   view_all,
  input logic [NUM_CPU-1:0]                irq_out,
  input logic                              req_valid,
  input logic [1:0]                        req_size,
  input logic                              rsp_valid,
  input logic                              rsp_err
);

  logic [NUM_SRC-1:0] rise_c;
  logic [NUM_SRC-1:0] fall_c;
  logic [NUM_SRC-1:0] spur_c;

  assign rise_c = dev_req & ~prev_q;
  assign fall_c = ~dev_req & prev_q & raw_q;
  assign spur_c = ~dev_req & prev_q & ~raw_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // R1: view of each processor is mask AND pending vector
    p_view_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
      view_all[c] == (mask_all[c] & raw_q));
    // R2 and R3: output follows the previous cycle's view
    p_irq_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] == $past(|view_all[c]));
  end

  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & $past(rise_c)) == $past(rise_c));

  p_fall_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & $past(fall_c)) == '0);

  p_spur_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & $past(spur_c)) == '0);

  p_rsp_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_size_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'b11) |=> rsp_err);

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_size != 2'b11) |=> $stable(mask_all));

endmodule

bind dev_irq_router dev_irq_router_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_req   (dev_req),
  .prev_q    (src_prev),
  .raw_q     (src_raw),
  .mask_all  (mask_all),
  .view_all  (view_all),
  .irq_out   (irq_out),
  .req_valid (req_valid),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err)
);

// File: tb/dev_irq_router_tb.sv
`timescale 1ns/1ps
module dev_irq_router_tb;

  logic        clk;
  logic        rst_n;
  logic [63:0] dev_req;
  logic        req_valid;
  logic        req_we;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dev_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_raw, m_prev;
  logic [63:0] m_mask [4];
  logic [3:0]  m_irq;
  logic        m_rv, m_err;
  logic [63:0] m_rd;

  function automatic int m_decode(input logic [11:0] a, output int ix);
    int r;
    ix = 0;
    if (a[11]) begin
      ix = int'(a[9:4]);
      if (ix >= 4) return 0;
      return a[10] ? 2 : 1;
    end
    r = int'(a[10:6]);
    if (r < 4) begin ix = r; return 1; end
    if (r < 8) begin ix = r - 4; return 2; end
    if (r == 8) return 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = '0; m_prev = '1; m_irq = '0;
      m_rv = 0; m_err = 0; m_rd = '0;
      foreach (m_mask[i]) m_mask[i] = '0;
    end else begin
      automatic logic [63:0] nraw = m_raw;
      automatic int ix;
      automatic int k;
      automatic bit bad;
      for (int c = 0; c < 4; c++) m_irq[c] = |(m_mask[c] & m_raw);
      for (int b = 0; b < 64; b++) begin
        if (dev_req[b] && !m_prev[b]) nraw[b] = 1'b1;
        else if (!dev_req[b] && m_prev[b] && m_raw[b]) nraw[b] = 1'b0;
      end
      m_rv = req_valid; m_err = 0; m_rd = '0;
      if (req_valid) begin
        k = m_decode(req_addr, ix);
        bad = (req_size != 2'b11) || (k == 0) || (req_we && k != 1);
        m_err = bad;
        if (!bad && !req_we)
          m_rd = (k == 1) ? m_mask[ix] : (k == 2) ? (m_mask[ix] & m_raw) : m_raw;
        if (!bad && req_we) m_mask[ix] = req_wdata;
      end
      m_raw = nraw; m_prev = dev_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R5/R12 model irq_out", {60'd0, irq_out}, {60'd0, m_irq});
      chk("R10 model rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rv});
      if (m_rv) begin
        chk("R7/R8/R9 model rsp_err", {63'd0, rsp_err}, {63'd0, m_err});
        chk("R1/R7 model rsp_rdata", rsp_rdata, m_rd);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic csr(input bit we, input logic [11:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    chk("R10 rsp_valid after request", {63'd0, rsp_valid}, 64'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic wr_ok(input logic [11:0] a, input logic [63:0] wd);
    logic [63:0] rd; logic er;
    csr(1, a, 2'b11, wd, rd, er);
    chk("R7 legal mask write err", {63'd0, er}, 64'd0);
  endtask

  task automatic rd_exp(input string tag, input logic [11:0] a, input logic [63:0] exp,
                        input logic exp_err);
    logic [63:0] rd; logic er;
    csr(0, a, 2'b11, '0, rd, er);
    chk(tag, rd, exp);
    chk({tag, " err"}, {63'd0, er}, {63'd0, exp_err});
  endtask

  initial begin
    logic [63:0] rd; logic er;
    rst_n = 0; dev_req = 64'h20; req_valid = 0; req_we = 0;
    req_addr = '0; req_size = 2'b11; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq_out after reset", {60'd0, irq_out}, 64'd0);
    chk("R11 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    rd_exp("R11 mask0 after reset", 12'h000, 64'd0, 0);
    rd_exp("R6 R11 pending empty with line 5 held high", 12'h200, 64'd0, 0);

    // program masks: cpu0 bits 4..7, cpu1 bit 40 (banked), cpu2 all, cpu3 none
    wr_ok(12'h000, 64'hF0);
    wr_ok(12'h810, 64'd1 << 40);
    wr_ok(12'h080, '1);
    rd_exp("R7 mask1 flat read", 12'h040, 64'd1 << 40, 0);
    rd_exp("R7 mask2 banked read", 12'h820, '1, 0);

    // R4 rising line 6
    @(negedge clk); dev_req[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 irq after rise of line 6", {60'd0, irq_out}, 64'h5);
    rd_exp("R4 R6 pending holds only bit 6", 12'h200, 64'd1 << 6, 0);
    rd_exp("R1 view cpu0 flat", 12'h100, 64'd1 << 6, 0);
    rd_exp("R1 view cpu1 banked", 12'hC10, 64'd0, 0);

    // R6 spurious fall of line 5
    @(negedge clk); dev_req[5] = 1'b0;
    repeat (2) @(negedge clk);
    rd_exp("R6 spurious fall ignored", 12'h200, 64'd1 << 6, 0);

    // R3 disable pending bit on cpu0
    wr_ok(12'h000, 64'd0);
    @(negedge clk);
    chk("R3 cpu0 withdrawn by mask write", {60'd0, irq_out}, 64'h4);

    // R2 enable pending bit on cpu1 (banked)
    wr_ok(12'h810, 64'd1 << 6);
    @(negedge clk);
    chk("R2 cpu1 raised by mask write", {60'd0, irq_out}, 64'h6);

    // R5 falling line 6
    @(negedge clk); dev_req[6] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 all withdrawn after fall", {60'd0, irq_out}, 64'h0);
    rd_exp("R5 pending cleared", 12'h200, 64'd0, 0);

    // R12 mask write and rising edge in the same cycle
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 12'h0C0; req_size = 2'b11;
    req_wdata = 64'd1 << 40; dev_req[40] = 1'b1;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    chk("R12 same-cycle write err", {63'd0, rsp_err}, 64'd0);
    @(negedge clk);
    chk("R12 combined irq", {60'd0, irq_out}, 64'hC);
    rd_exp("R12 view cpu3", 12'h1C0, 64'd1 << 40, 0);

    // R8 illegal sizes
    csr(0, 12'h200, 2'b10, '0, rd, er);
    chk("R8 narrow read err", {63'd0, er}, 64'd1);
    chk("R8 narrow read data", rd, 64'd0);
    csr(1, 12'h000, 2'b01, '1, rd, er);
    chk("R8 narrow write err", {63'd0, er}, 64'd1);
    rd_exp("R8 mask0 unchanged", 12'h000, 64'd0, 0);

    // R9 illegal targets
    csr(1, 12'h100, 2'b11, '1, rd, er);
    chk("R9 write to view err", {63'd0, er}, 64'd1);
    csr(1, 12'h200, 2'b11, '0, rd, er);
    chk("R9 write to pending err", {63'd0, er}, 64'd1);
    rd_exp("R9 pending unchanged", 12'h200, 64'd1 << 40, 0);
    rd_exp("R9 banked index 5", 12'h850, 64'd0, 1);
    rd_exp("R9 unmapped flat 9", 12'h240, 64'd0, 1);
    @(negedge clk);
    chk("R10 no response without request", {63'd0, rsp_valid}, 64'd0);
    chk("R9 irq unchanged by errors", {60'd0, irq_out}, 64'hC);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule